// File: doc/BRIEF.md
# Strap-Configured Multifunction GPIO Pin Mux

This block owns three shared pins. Each pin can work as a general-purpose I/O or carry an alternate signal. The alternate signal is a memory address bit, or for the middle pin a peripheral power-enable. The function of each pin is chosen once by a three-bit strap bus. The bus is captured while the synchronous reset is held, and the value seen on the last clock edge with reset asserted stays in force until the next reset.

Software controls the GPIO side through a small register port. A direction register sets each GPIO as input or output. An output-data register gives the level a GPIO drives. A read-only input register returns the sampled pad levels. A pin that is strapped to its alternate function always drives, and it takes its level from the alternate source. For such a pin the direction bit still exists and can be written and read back, but it no longer reaches the pad.

Top module: `gpio_pinmux`

## Requirements
- R1: On the first clock edge after reset is released, the direction and output-data registers both read 0, and every pin strapped as GPIO has pad_oe low. While reset is asserted, pad_oe and pad_out are 0.
- R2: The strap value applied on the last clock edge with rst high decides the pin functions. Changes on strap while rst is low have no effect.
- R3: With strap[1:0] equal to 00, GPIO1 and GPIO3 are both GPIOs. With 01, GPIO1 is a GPIO and GPIO3 carries address bit 9. With 10 or 11, GPIO1 carries address bit 10 and GPIO3 carries address bit 9.
- R4: When strap[2] is 1, GPIO2 carries the power-enable. Otherwise GPIO2 is a GPIO when strap[1:0] is 00, and carries address bit 11 in every other case.
- R5: In the three registers, register bit 1 maps to GPIO1, bit 2 to GPIO2 and bit 3 to GPIO3. The direction register is at address 0 and the output-data register at address 1. A direction bit of 1 means output. For a GPIO pin, pad_oe and pad_out follow the direction and output-data bits one clock after the register write.
- R6: A pin in alternate function has pad_oe at 1. Its pad_out, one clock after the source changes, is the selected source: alt_addr[1] for address bit 10, alt_addr[2] for bit 11, alt_addr[0] for bit 9, or alt_pwr for the power-enable.
- R7: A direction bit of a pin in alternate function can still be written and read back, but it has no effect on that pin's pad_oe or pad_out.
- R8: Register bits 0 and 7:4 read as 0 and ignore writes. Address 3 reads 0. Writes to addresses 2 and 3 change nothing.
- R9: The input register at address 2 captures pad_in for each GPIO pin on every clock and returns 0 for each pin in alternate function.
- R10: reg_rdata is registered. It returns the register selected by reg_addr on the previous edge, with the contents it had before any write on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap is captured while high |
| strap | input | 3 | Configuration strap bus; bit 2 selects the power-enable on GPIO2 |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| alt_addr | input | 3 | Alternate address sources: bit 0 = address 9, bit 1 = address 10, bit 2 = address 11 |
| alt_pwr | input | 1 | Alternate power-enable source |
| pad_in | input | 3 | Pad input levels, index 0 = GPIO1 |
| pad_oe | output | 3 | Pad output enables, index 0 = GPIO1 |
| pad_out | output | 3 | Pad output levels, index 0 = GPIO1 |

## Verification
The hardest condition to reach is a pin that sits in its alternate function while software drives its direction bit both ways. The stimulus also has to make the strap bus change right after reset is released, so that a latch which keeps sampling would show up at once. The bench runs all eight strap values through a reset release. Each time it puts the inverse value on the strap bus one cycle later. It then writes all-ones and all-zeros into the direction register and checks that only the GPIO-strapped pins respond. Random register traffic, pad levels and alternate sources follow, and a behavioural model checks every cycle.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
  localparam int NPIN    = 3;
  localparam int STRAP_W = 3;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int PIN_LSB = 1;

  typedef enum logic [1:0] {
    MODE_ALL_GPIO = 2'd0,
    MODE_G1_ONLY  = 2'd1,
    MODE_ADDR_A   = 2'd2,
    MODE_ADDR_B   = 2'd3
  } strap_mode_e;
endpackage

// File: rtl/gpio_strap_latch.sv
module gpio_strap_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] strap,
  output logic [W-1:0] strap_q
);
  // Tracks the strap bus while reset is held; freezes at release.
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap;
  end
endmodule

// File: rtl/gpio_fn_decode.sv
module gpio_fn_decode
  import gpio_pinmux_pkg::*;
(
  input  logic [STRAP_W-1:0] strap_q,
  output logic [NPIN-1:0]    gpio_en,
  output logic               pwr_sel
);
  strap_mode_e mode;

  always_comb begin
    mode    = strap_mode_e'(strap_q[1:0]);
    gpio_en = '0;
    unique case (mode)
      MODE_ALL_GPIO: gpio_en = 3'b111;
      MODE_G1_ONLY:  gpio_en = 3'b001;
      MODE_ADDR_A,
      MODE_ADDR_B:   gpio_en = 3'b000;
      default:       gpio_en = 3'b000;
    endcase
    pwr_sel = strap_q[2];
    if (pwr_sel) gpio_en[1] = 1'b0;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int NPIN      = 3,
  parameter int PIN_LSB   = 1,
  parameter int DIR_ADDR  = 0,
  parameter int DOUT_ADDR = 1,
  parameter int DIN_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NPIN-1:0]   gpio_en,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   dir_bits,
  output logic [NPIN-1:0]   dout_bits
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(DOUT_ADDR);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(DIN_ADDR);

  logic [NPIN-1:0]   din_q;
  logic [NPIN-1:0]   sel_field;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;

  always_comb begin
    unique case (reg_addr)
      A_DIR:   sel_field = dir_bits;
      A_DOUT:  sel_field = dout_bits;
      A_DIN:   sel_field = din_q;
      default: sel_field = '0;
    endcase
    rd_next = '0;
    rd_next[PIN_LSB +: NPIN] = sel_field;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_bits  <= '0;
      dout_bits <= '0;
      din_q     <= '0;
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_next;
      din_q     <= pad_in & gpio_en;
      if (reg_wr && reg_addr == A_DIR)  dir_bits  <= reg_wdata[PIN_LSB +: NPIN];
      if (reg_wr && reg_addr == A_DOUT) dout_bits <= reg_wdata[PIN_LSB +: NPIN];
    end
  end
endmodule

// File: rtl/gpio_pad_stage.sv
module gpio_pad_stage #(
  parameter int NPIN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] gpio_en,
  input  logic [NPIN-1:0] dir_bits,
  input  logic [NPIN-1:0] dout_bits,
  input  logic [NPIN-1:0] alt_src,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
      end else if (gpio_en[i]) begin
        pad_oe[i]  <= dir_bits[i];
        pad_out[i] <= dout_bits[i];
      end else begin
        pad_oe[i]  <= 1'b1;
        pad_out[i] <= alt_src[i];
      end
    end
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pinmux_pkg::*;
#(
  parameter int DIR_ADDR  = 0,
  parameter int DOUT_ADDR = 1,
  parameter int DIN_ADDR  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NPIN-1:0]    alt_addr,
  input  logic               alt_pwr,
  input  logic [NPIN-1:0]    pad_in,
  output logic [NPIN-1:0]    pad_oe,
  output logic [NPIN-1:0]    pad_out
);
  logic [STRAP_W-1:0] strap_q;
  logic [NPIN-1:0]    gpio_en;
  logic               pwr_sel;
  logic [NPIN-1:0]    dir_bits;
  logic [NPIN-1:0]    dout_bits;
  logic [NPIN-1:0]    alt_src;

  gpio_strap_latch #(.W(STRAP_W)) u_strap (
    .clk(clk), .rst(rst), .strap(strap), .strap_q(strap_q)
  );

  gpio_fn_decode u_dec (
    .strap_q(strap_q), .gpio_en(gpio_en), .pwr_sel(pwr_sel)
  );

  // Alternate sources: GPIO1 <- addr10, GPIO2 <- addr11 or power, GPIO3 <- addr9
  assign alt_src[0] = alt_addr[1];
  assign alt_src[1] = pwr_sel ? alt_pwr : alt_addr[2];
  assign alt_src[2] = alt_addr[0];

  gpio_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NPIN(NPIN), .PIN_LSB(PIN_LSB),
    .DIR_ADDR(DIR_ADDR), .DOUT_ADDR(DOUT_ADDR), .DIN_ADDR(DIN_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_en(gpio_en),
    .pad_in(pad_in), .dir_bits(dir_bits), .dout_bits(dout_bits)
  );

  gpio_pad_stage #(.NPIN(NPIN)) u_pads (
    .clk(clk), .rst(rst), .gpio_en(gpio_en), .dir_bits(dir_bits),
    .dout_bits(dout_bits), .alt_src(alt_src), .pad_oe(pad_oe), .pad_out(pad_out)
  );
endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk
  import gpio_pinmux_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [STRAP_W-1:0] strap_q,
  input logic [NPIN-1:0]    gpio_en,
  input logic [NPIN-1:0]    dir_bits,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NPIN-1:0]    pad_oe,
  input logic [NPIN-1:0]    pad_out
);
  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(((1 << NPIN) - 1) << PIN_LSB);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (pad_oe == '0 && pad_out == '0));

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_q));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~FIELD_MASK) == '0);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    // R6
    alt_drives_chk: assert property (@(posedge clk) disable iff (rst)
      !gpio_en[i] |=> pad_oe[i]);

    // R5
    gpio_dir_chk: assert property (@(posedge clk) disable iff (rst)
      gpio_en[i] |=> pad_oe[i] == $past(dir_bits[i]));

    // R9
    alt_in_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_addr == ADDR_W'(2) && !gpio_en[i]) |=> !reg_rdata[PIN_LSB + i]);
  end
endmodule

bind gpio_pinmux gpio_pinmux_chk u_chk (
  .clk(clk), .rst(rst), .strap_q(strap_q), .gpio_en(gpio_en),
  .dir_bits(dir_bits), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/gpio_pinmux_bench.sv
module gpio_pinmux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] strap = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] alt_addr = '0;
  logic       alt_pwr = 1'b0;
  logic [2:0] pad_in = '0;
  logic [2:0] pad_oe;
  logic [2:0] pad_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pinmux u_gpio_pinmux (
    .clk(clk), .rst(rst), .strap(strap), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_addr(alt_addr),
    .alt_pwr(alt_pwr), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  // Behavioural reference model
  logic [2:0] m_strap = '0;
  logic [2:0] m_dir = '0, m_dout = '0, m_inq = '0;
  logic [7:0] m_rdata = '0;
  logic [2:0] m_oe = '0, m_out = '0;

  function automatic logic [2:0] gpio_mask(input logic [2:0] s);
    logic [2:0] g;
    g[0] = (s[1] == 1'b0);                       // R3
    g[2] = (s[1:0] == 2'b00);                    // R3
    g[1] = (s[2] == 1'b0) && (s[1:0] == 2'b00);  // R4
    return g;
  endfunction

  function automatic logic [2:0] alt_value(input logic [2:0] s, input logic [2:0] a, input logic p);
    logic [2:0] v;
    v[0] = a[1];
    v[1] = s[2] ? p : a[2];
    v[2] = a[0];
    return v;
  endfunction

  always @(posedge clk) begin
    logic [2:0] g;
    logic [2:0] fld;
    if (rst) begin
      m_strap = strap;
      m_dir = '0; m_dout = '0; m_inq = '0; m_rdata = '0; m_oe = '0; m_out = '0;
    end else begin
      g = gpio_mask(m_strap);
      case (reg_addr)
        2'd0: fld = m_dir;
        2'd1: fld = m_dout;
        2'd2: fld = m_inq;
        default: fld = '0;
      endcase
      m_rdata = {4'b0, fld, 1'b0};
      for (int i = 0; i < 3; i++) begin
        if (g[i]) begin m_oe[i] = m_dir[i]; m_out[i] = m_dout[i]; end
        else begin m_oe[i] = 1'b1; m_out[i] = alt_value(m_strap, alt_addr, alt_pwr)[i]; end
      end
      m_inq = pad_in & g;
      if (reg_wr && reg_addr == 2'd0) m_dir = reg_wdata[3:1];
      if (reg_wr && reg_addr == 2'd1) m_dout = reg_wdata[3:1];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R10 reg_rdata vs model", reg_rdata, m_rdata);
      chk("R5/R6/R7 pad_oe vs model", {5'b0, pad_oe}, {5'b0, m_oe});
      chk("R5/R6 pad_out vs model", {5'b0, pad_out}, {5'b0, m_out});
    end
  end

  task automatic cyc(input logic [1:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_wdata = d;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] alt_m;
    for (int s = 0; s < 8; s++) begin
      // reset with wrong strap first, correct strap on the last reset edge
      @(negedge clk);
      cmp_on = 0; rst = 1; strap = ~3'(s); reg_wr = 0; reg_addr = 0;
      alt_addr = 0; alt_pwr = 0; pad_in = 0;
      repeat (2) @(negedge clk);
      chk("R1 pad_oe in reset", {5'b0, pad_oe}, 8'h00);
      strap = 3'(s);
      @(negedge clk);
      rst = 0; strap = ~3'(s);   // R2: strap moves after release
      cmp_on = 1;
      alt_m = ~gpio_mask(3'(s));
      @(negedge clk);
      // R3 / R4: alternate pins drive, GPIO pins are inputs
      chk("R3 GPIO1/GPIO3 oe after release", {6'b0, pad_oe[2], pad_oe[0]}, {6'b0, alt_m[2], alt_m[0]});
      chk("R4 GPIO2 oe after release", {7'b0, pad_oe[1]}, {7'b0, alt_m[1]});
      chk("R1 dir reads 0", reg_rdata, 8'h00);
      cyc(2'd0, 1, 8'hFF);
      cyc(2'd0, 0, 8'h00);
      @(negedge clk);
      chk("R8 dir readback masked", reg_rdata, 8'h0E);
      chk("R5 all outputs", {5'b0, pad_oe}, 8'h07);
      cyc(2'd0, 1, 8'h00);
      cyc(2'd0, 0, 8'h00);
      @(negedge clk);
      chk("R7 alt pins ignore dir clear", {5'b0, pad_oe}, {5'b0, alt_m});
      // R6: alternate sources
      alt_addr = 3'b010; alt_pwr = 1'b1;
      @(negedge clk);
      chk("R6 alt pad_out", {5'b0, pad_out},
          {5'b0, alt_value(3'(s), 3'b010, 1'b1) & alt_m});
      // R9: input register
      pad_in = 3'b111; reg_addr = 2'd2;
      repeat (2) @(negedge clk);
      chk("R9 input register", reg_rdata, {4'b0, ~alt_m, 1'b0});
      // R8: writes to input and unused addresses change nothing
      cyc(2'd3, 1, 8'hFF);
      cyc(2'd3, 0, 8'h00);
      @(negedge clk);
      chk("R8 addr3 reads 0", reg_rdata, 8'h00);
      // random traffic compared each cycle against the model
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        reg_addr = 2'($urandom);
        reg_wr = 1'($urandom);
        reg_wdata = 8'($urandom);
        alt_addr = 3'($urandom);
        alt_pwr = 1'($urandom);
        pad_in = 3'($urandom);
      end
      reg_wr = 0;
      repeat (2) @(negedge clk);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule